// File: doc/BRIEF.md
# Software-Refilled Page Translation Buffer

This block is a small fully associative cache of page translations. A lookup port receives a virtual address and treats its upper bits as a virtual page number and its low bits as the offset within the page. When a resident entry holds that page number, the block reports a hit in the same cycle. The physical address it returns is the stored physical page number with the untouched offset appended below it. When no entry matches, the block reports a miss and does not translate the address.

The block has no hardware table walker. Refill comes from a software handler through a write port that supplies a page-number pair. A write to a page number that is already resident overwrites that entry, so duplicate entries cannot arise. A write to a new page number takes the lowest-numbered empty entry. When every entry is in use, the write evicts the entry chosen by a round-robin pointer.

A maintenance port serves context switches and shootdowns. It can drop the entry of one page number, or it can empty the whole buffer. When a maintenance command and a write arrive in the same cycle, the maintenance command is applied first and the write is then applied on top of its result.

Top module: `vpage_xlat`

## Requirements
- R1: After a synchronous active-low reset every entry is empty, so every lookup misses.
- R2: A 32-bit lookup address is split into a virtual page number in bits 31:12 and a page offset in bits 11:0.
- R3: While `lk_req` is high and a valid entry holds the virtual page number, `lk_hit` is 1 and `lk_paddr` equals the stored 20-bit physical page number in bits 31:12 with the lookup offset in bits 11:0. The result is combinational, and a write is visible to lookups from the next cycle.
- R4: While `lk_req` is high and no valid entry matches, `lk_miss` is 1, `lk_hit` is 0 and `lk_paddr` is 0. While `lk_req` is low, `lk_hit`, `lk_miss` and `lk_paddr` are all 0.
- R5: A write whose virtual page number is already resident replaces the physical page number of that entry. No second entry is created, so every other resident translation stays resident.
- R6: A write of a new virtual page number goes to the lowest-indexed empty entry when one exists. Sixteen distinct writes into an empty buffer therefore all stay resident.
- R7: A write of a new virtual page number into a full buffer evicts the entry at a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping after entry 15, on each such eviction only.
- R8: A flush command (`flush_en`) empties every entry.
- R9: An invalidate command (`inv_en`) empties only the entry whose virtual page number equals `inv_vpn`. All other entries are untouched, and the command has no effect if no entry matches.
- R10: When a flush or an invalidate occurs in the same cycle as a write, the maintenance command acts first and the write is then applied to the result, so the written translation is resident afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Request with no resident translation |
| lk_paddr | output | 32 | Translated physical address, 0 unless hit |
| wr_en | input | 1 | Software refill write |
| wr_vpn | input | 20 | Virtual page number to install |
| wr_ppn | input | 20 | Physical page number to install |
| inv_en | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Virtual page number to invalidate |
| flush_en | input | 1 | Empty the whole buffer |

## Verification
Any fault in the valid bits, stored page numbers or replacement pointer shows up at the lookup port. Because the lookup reads the stored state combinationally, it appears in the first cycle after the faulty update. A wrong replacement choice is visible as soon as a later lookup hits on a page that should have been evicted, or misses on one that should still be resident. The bench therefore keeps a reference model of the buffer. After every update it compares lookups of a small pool of page numbers against that model, so a corrupted entry cannot stay hidden for long.

// File: rtl/vpx_pkg.sv
// Package: types shared by the translation buffer's submodules.
// Assumes: nothing beyond standard SystemVerilog.
package vpx_pkg;
    // How the slot for a software write was chosen.
    typedef enum logic [1:0] {
        SLOT_NONE  = 2'd0,
        SLOT_SAME  = 2'd1,
        SLOT_FREE  = 2'd2,
        SLOT_EVICT = 2'd3
    } slot_kind_e;
endpackage

// File: rtl/vpx_match.sv
// Module: parallel tag compare. Reports which valid entries hold a key.
// Assumes: the callers keep keys unique among valid entries, so hit_vec is
// one-hot or zero whenever en is high.
module vpx_match #(
    parameter int N  = 16,
    parameter int KW = 20
) (
    input  logic              en,
    input  logic [KW-1:0]     key,
    input  logic [N-1:0]      valid,
    input  logic [N-1:0][KW-1:0] tags,
    output logic [N-1:0]      hit_vec
);
    // One comparator per entry, gated by the entry's valid bit.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_vec[i] = en && valid[i] && (tags[i] == key);
    end
endmodule

// File: rtl/vpx_alloc.sv
// Module: picks the entry a software write lands in and owns the
// round-robin eviction pointer.
// Assumes: keep_valid is the valid vector after this cycle's maintenance,
// and same_vec holds at most one bit, which is set only where keep_valid is set.
module vpx_alloc #(
    parameter int N = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [N-1:0]  keep_valid,
    input  logic [N-1:0]  same_vec,
    output logic [N-1:0]  wr_sel
);
    import vpx_pkg::*;

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] rr_q;
    logic [N-1:0]     free_first;
    logic [N-1:0]     rr_vec;
    slot_kind_e       kind;

    // Lowest-indexed empty entry as a one-hot vector.
    always_comb begin
        free_first = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!keep_valid[i]) begin
                free_first    = '0;
                free_first[i] = 1'b1;
            end
        end
    end

    // Decode the round-robin pointer to a one-hot vector.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            rr_vec[i] = (rr_q == IDX_W'(i));
        end
    end

    // Choose the slot: existing entry, then empty entry, then the victim.
    always_comb begin
        if (!wr_en) begin
            kind   = SLOT_NONE;
            wr_sel = '0;
        end else if (|same_vec) begin
            kind   = SLOT_SAME;
            wr_sel = same_vec;
        end else if (|free_first) begin
            kind   = SLOT_FREE;
            wr_sel = free_first;
        end else begin
            kind   = SLOT_EVICT;
            wr_sel = rr_vec;
        end
    end

    // Advance the pointer only when it supplied the victim.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (kind == SLOT_EVICT) begin
            rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
        end
    end
endmodule

// File: rtl/vpx_store.sv
// Module: entry storage holding a valid bit, a virtual page number and a
// physical page number for each entry.
// Assumes: keep_valid already reflects flush and invalidate; wr_sel is one-hot
// or zero. Page numbers are not reset, since valid gates every use of them.
module vpx_store #(
    parameter int N  = 16,
    parameter int VW = 20,
    parameter int PW = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         keep_valid,
    input  logic [N-1:0]         wr_sel,
    input  logic [VW-1:0]        wr_vpn,
    input  logic [PW-1:0]        wr_ppn,
    output logic [N-1:0]         valid_q,
    output logic [N-1:0][VW-1:0] vpn_q,
    output logic [N-1:0][PW-1:0] ppn_q
);
    for (genvar i = 0; i < N; i++) begin : g_ent
        // Valid bit: cleared by reset, maintenance result plus write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
            end else begin
                valid_q[i] <= keep_valid[i] | wr_sel[i];
            end
        end

        // Page-number pair: loaded when this entry is the write target.
        always_ff @(posedge clk) begin
            if (wr_sel[i]) begin
                vpn_q[i] <= wr_vpn;
                ppn_q[i] <= wr_ppn;
            end
        end
    end
endmodule

// File: rtl/vpage_xlat.sv
// Module: software-refilled, fully associative page translation buffer.
// Lookup is combinational. Refill, single-page invalidate and flush take
// effect at the clock edge, with maintenance applied before a same-cycle write.
// Assumes: the page offset is OFF_W bits and is passed through untranslated.
module vpage_xlat #(
    parameter int VA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int PPN_W   = 20,
    parameter int ENTRIES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   lk_req,
    input  logic [VA_W-1:0]        lk_vaddr,
    output logic                   lk_hit,
    output logic                   lk_miss,
    output logic [PPN_W+OFF_W-1:0] lk_paddr,
    input  logic                   wr_en,
    input  logic [VA_W-OFF_W-1:0]  wr_vpn,
    input  logic [PPN_W-1:0]       wr_ppn,
    input  logic                   inv_en,
    input  logic [VA_W-OFF_W-1:0]  inv_vpn,
    input  logic                   flush_en
);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PA_W  = PPN_W + OFF_W;

    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
    logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
    logic [ENTRIES-1:0]            lk_hitv;
    logic [ENTRIES-1:0]            inv_hitv;
    logic [ENTRIES-1:0]            wr_hitv;
    logic [ENTRIES-1:0]            keep_valid;
    logic [ENTRIES-1:0]            same_vec;
    logic [ENTRIES-1:0]            wr_sel;
    logic [VPN_W-1:0]              lk_vpn;
    logic [OFF_W-1:0]              lk_off;
    logic [PPN_W-1:0]              lk_ppn;

    // Split the lookup address into page number and offset.
    assign lk_vpn = lk_vaddr[VA_W-1:OFF_W];
    assign lk_off = lk_vaddr[OFF_W-1:0];

    vpx_match #(.N(ENTRIES), .KW(VPN_W)) u_lk_match (
        .en(lk_req), .key(lk_vpn), .valid(valid_q), .tags(vpn_q), .hit_vec(lk_hitv)
    );

    vpx_match #(.N(ENTRIES), .KW(VPN_W)) u_inv_match (
        .en(inv_en), .key(inv_vpn), .valid(valid_q), .tags(vpn_q), .hit_vec(inv_hitv)
    );

    vpx_match #(.N(ENTRIES), .KW(VPN_W)) u_wr_match (
        .en(wr_en), .key(wr_vpn), .valid(valid_q), .tags(vpn_q), .hit_vec(wr_hitv)
    );

    // Valid vector after this cycle's maintenance, before the write.
    assign keep_valid = valid_q & ~{ENTRIES{flush_en}} & ~inv_hitv;
    // A write may reuse only an entry that survives maintenance.
    assign same_vec   = wr_hitv & keep_valid;

    vpx_alloc #(.N(ENTRIES)) u_alloc (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .keep_valid(keep_valid), .same_vec(same_vec), .wr_sel(wr_sel)
    );

    vpx_store #(.N(ENTRIES), .VW(VPN_W), .PW(PPN_W)) u_store (
        .clk(clk), .rst_n(rst_n), .keep_valid(keep_valid), .wr_sel(wr_sel),
        .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
        .valid_q(valid_q), .vpn_q(vpn_q), .ppn_q(ppn_q)
    );

    // Select the physical page number of the single matching entry.
    always_comb begin
        lk_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            lk_ppn = lk_ppn | (lk_hitv[i] ? ppn_q[i] : '0);
        end
    end

    // Drive the lookup result: the translated address or a miss.
    always_comb begin
        lk_hit   = |lk_hitv;
        lk_miss  = lk_req && !lk_hit;
        lk_paddr = lk_hit ? PA_W'({lk_ppn, lk_off}) : '0;
    end
endmodule

// File: rtl/vpx_checks.sv
// Module: assertion checker bound to vpage_xlat.
// Assumes: it sees the top's ports and its stored entry state.
module vpx_checks #(
    parameter int VA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int PPN_W   = 20,
    parameter int ENTRIES = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   lk_req,
    input logic [VA_W-1:0]        lk_vaddr,
    input logic                   lk_hit,
    input logic                   lk_miss,
    input logic [PPN_W+OFF_W-1:0] lk_paddr,
    input logic                   wr_en,
    input logic [VA_W-OFF_W-1:0]  wr_vpn,
    input logic                   inv_en,
    input logic [VA_W-OFF_W-1:0]  inv_vpn,
    input logic                   flush_en,
    input logic [ENTRIES-1:0]     lk_hitv,
    input logic [ENTRIES-1:0]     valid_q,
    input logic [ENTRIES-1:0][VA_W-OFF_W-1:0] vpn_q
);
    // True when some valid entry holds the page number.
    function automatic logic resident(input logic [VA_W-OFF_W-1:0] k);
        logic r = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (valid_q[i] && vpn_q[i] == k) r = 1'b1;
        end
        return r;
    endfunction

    // R5: never more than one matching entry.
    p_single_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hitv));

    // R2: offset passes through on a hit.
    p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);

    // R4: a miss carries no translation.
    p_miss_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (!lk_hit && lk_paddr == '0));

    // R4: no request, no result.
    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> (!lk_hit && !lk_miss));

    // R6: a written page is resident next cycle.
    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> resident($past(wr_vpn)));

    // R9: an invalidated page is gone unless rewritten.
    p_inv_removes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !(wr_en && wr_vpn == inv_vpn)) |=> !resident($past(inv_vpn)));

    // R8: flush empties everything.
    p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_en && !wr_en) |=> valid_q == '0);

    // R10: flush with a write leaves exactly the written entry.
    p_flush_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_en && wr_en) |=> $countones(valid_q) == 1);
endmodule

bind vpage_xlat vpx_checks #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .ENTRIES(ENTRIES)
) u_vpx_checks (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
    .wr_en(wr_en), .wr_vpn(wr_vpn), .inv_en(inv_en), .inv_vpn(inv_vpn),
    .flush_en(flush_en), .lk_hitv(lk_hitv), .valid_q(valid_q), .vpn_q(vpn_q)
);

// File: tb/test_vpage_xlat.sv
module test_vpage_xlat;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_hit, lk_miss;
    logic [31:0] lk_paddr;
    logic        wr_en = 1'b0;
    logic [19:0] wr_vpn = '0, wr_ppn = '0;
    logic        inv_en = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic        flush_en = 1'b0;

    int checks = 0;
    int errors = 0;

    // Reference model of the buffer.
    bit        m_v   [N];
    bit [19:0] m_vpn [N];
    bit [19:0] m_ppn [N];
    int        m_rr;

    always #4 clk = ~clk;

    vpage_xlat i_vpage_xlat (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_paddr(lk_paddr),
        .wr_en(wr_en), .wr_vpn(wr_vpn), .wr_ppn(wr_ppn),
        .inv_en(inv_en), .inv_vpn(inv_vpn), .flush_en(flush_en)
    );

    // Pool page number k, with upper bits set so the split is exercised.
    function automatic bit [19:0] pv(int k);
        return 20'hA5000 + 20'(k);
    endfunction

    function automatic void model_reset();
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        m_rr = 0;
    endfunction

    // Apply one clock edge of the requirements to the model (R5-R10).
    function automatic void model_step(bit w, bit [19:0] wv, bit [19:0] wp,
                                       bit iv, bit [19:0] ik, bit fl);
        int slot = -1;
        for (int i = 0; i < N; i++) begin
            if (fl || (iv && m_v[i] && m_vpn[i] == ik)) m_v[i] = 1'b0;
        end
        if (!w) return;
        for (int i = 0; i < N; i++) if (slot < 0 && m_v[i] && m_vpn[i] == wv) slot = i;
        for (int i = 0; i < N; i++) if (slot < 0 && !m_v[i]) slot = i;
        if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % N;
        end
        m_v[slot]   = 1'b1;
        m_vpn[slot] = wv;
        m_ppn[slot] = wp;
    endfunction

    // One clock with the given commands; inputs change 2 ns after the edge.
    task automatic cyc(bit w, bit [19:0] wv, bit [19:0] wp,
                       bit iv, bit [19:0] ik, bit fl);
        wr_en = w; wr_vpn = wv; wr_ppn = wp;
        inv_en = iv; inv_vpn = ik; flush_en = fl;
        @(posedge clk);
        model_step(w, wv, wp, iv, ik, fl);
        #2;
        wr_en = 1'b0; inv_en = 1'b0; flush_en = 1'b0;
    endtask

    // Drive a lookup and compare against the model.
    task automatic look(string req, bit rq, bit [19:0] vpn, bit [11:0] off);
        bit        e_hit = 1'b0;
        bit [31:0] e_pa  = '0;
        lk_req = rq;
        lk_vaddr = {vpn, off};
        #1;
        if (rq) begin
            for (int i = 0; i < N; i++) begin
                if (m_v[i] && m_vpn[i] == vpn) begin
                    e_hit = 1'b1;
                    e_pa  = {m_ppn[i], off};
                end
            end
        end
        checks++;
        if (lk_hit !== e_hit || lk_miss !== (rq && !e_hit) || lk_paddr !== e_pa) begin
            errors++;
            $display("FAIL %s vaddr=%h hit/miss/pa=%b/%b/%h expected %b/%b/%h",
                     req, {vpn, off}, lk_hit, lk_miss, lk_paddr,
                     e_hit, rq && !e_hit, e_pa);
        end
        lk_req = 1'b0;
    endtask

    // Look up every pool page number.
    task automatic look_pool(string req, int cnt);
        for (int k = 0; k < cnt; k++) look(req, 1'b1, pv(k), 12'(k * 37 + 5));
    endtask

    initial begin
        void'($urandom(32'd20240607));
        model_reset();
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1: empty after reset.
        look_pool("R1", 20);
        // R4: idle port produces nothing.
        look("R4", 1'b0, pv(0), 12'h123);

        // R6, R3, R2: fill all entries.
        for (int k = 0; k < 16; k++) cyc(1'b1, pv(k), 20'(k * 3 + 1), 1'b0, '0, 1'b0);
        look_pool("R6", 16);
        look("R2", 1'b1, pv(9), 12'hFFF);
        look("R3", 1'b1, pv(2), 12'h000);

        // R5: overwrite resident page.
        cyc(1'b1, pv(5), 20'hBEEF5, 1'b0, '0, 1'b0);
        look_pool("R5", 17);

        // R7: evictions follow the pointer from entry 0.
        cyc(1'b1, pv(16), 20'h11111, 1'b0, '0, 1'b0);
        look("R7", 1'b1, pv(0), 12'h010);
        cyc(1'b1, pv(17), 20'h22222, 1'b0, '0, 1'b0);
        look_pool("R7", 18);

        // R9: single-page invalidate and an absent page.
        cyc(1'b0, '0, '0, 1'b1, pv(3), 1'b0);
        look_pool("R9", 18);
        cyc(1'b0, '0, '0, 1'b1, pv(99), 1'b0);
        look_pool("R9", 18);

        // R10: invalidate and rewrite the same page together.
        cyc(1'b1, pv(4), 20'h44444, 1'b1, pv(4), 1'b0);
        look_pool("R10", 18);

        // R8: flush.
        cyc(1'b0, '0, '0, 1'b0, '0, 1'b1);
        look_pool("R8", 18);
        // R10: flush with write.
        cyc(1'b1, pv(7), 20'h77777, 1'b0, '0, 1'b1);
        look_pool("R10", 18);

        // Random mix: R3, R5, R6, R7, R9, R10.
        for (int t = 0; t < 3000; t++) begin
            bit w  = ($urandom % 10) < 6;
            bit iv = ($urandom % 10) < 2;
            bit fl = ($urandom % 100) < 2;
            cyc(w, pv($urandom % 24), 20'($urandom), iv, pv($urandom % 24), fl);
            look("R3", ($urandom % 10) != 0, pv($urandom % 24), 12'($urandom));
        end

        // R1: reset in the middle of use.
        rst_n = 1'b0;
        @(posedge clk);
        model_reset();
        #2 rst_n = 1'b1;
        look_pool("R1", 24);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule